// File: doc/BRIEF.md
# Virtual-Channel Input Unit Controller

This block serves one input port of a packet router that multiplexes several virtual channels (VCs) over a single link. Flits arrive one per cycle. Each flit carries a VC number and a two-bit type. The flit is stored in a small FIFO that belongs to its VC. Each VC also keeps a packet-level record: a phase, the output port chosen for the packet, the output VC granted to it, and a count of free downstream buffers.

The phase walks from idle to routing, then to waiting for an output VC, then to active. In the routing phase the VC raises a request to an external route unit. In the waiting phase it raises a request to an external VC allocator. Only the first flit of a packet drives these two steps. Once active, the VC bids for a one-flit switch slot whenever it holds a flit and has a downstream credit. When the switch allocator grants the bid, the front flit is presented on the output together with the stored port and output VC, and the VC spends one credit. Credits come back from downstream on a separate return channel. Per-VC stall indications tell packet-level waits apart from flit-level waits.

Top module: `vc_input_unit`

## Requirements
- R1: After reset every VC is idle with an empty FIFO and a full credit count of CREDITS. No request, bid, output flit, stall or error is raised.
- R2: A flit written into an empty idle VC is stored at the clock edge on which it is accepted. That VC's `rc_req` bit rises after the following edge, and not before.
- R3: While `rc_req[v]` is high, `rc_ack[v]` stores `rc_port` as the VC's route. From the next cycle `va_req[v]` is high and `rc_req[v]` is low. The stored route appears on `out_port` with every flit of the packet.
- R4: While `va_req[v]` is high, `va_grant[v]` stores `va_ovc` and makes the VC active from the next cycle. The stored value appears on `out_ovc`.
- R5: `sa_req[v]` is high exactly when VC v is active, its FIFO is non-empty and its credit count is above zero.
- R6: If `sa_grant[v]` meets a high `sa_req[v]`, the front flit of VC v is presented in the same cycle: `out_valid` goes high and `out_type` and `out_data` carry the flit. The flit is removed at the edge, and the credit count drops by one. Flits leave a VC in arrival order.
- R7: A credit return (`cred_valid` with `cred_vc`) adds one credit to that VC. A return and a granted departure on the same VC in the same cycle leave the count unchanged.
- R8: When a flit whose type has bit 1 set (tail 2'b10 or single 2'b11) departs, the VC becomes idle if that flit was its last stored one. Otherwise it enters routing, and `rc_req` is high in the next cycle.
- R9: Type encoding: 2'b01 head, 2'b00 body, 2'b10 tail, 2'b11 single-flit packet. Body and tail flits never raise `rc_req` or `va_req`; they only wait for switch slots.
- R10: `stall_pkt[v]` is high when VC v is routing without `rc_ack[v]`, or waiting without `va_grant[v]`. `stall_flit[v]` is high when VC v is active and no flit departs from it in that cycle.
- R11: A flit sent to a VC whose FIFO holds DEPTH flits raises `overflow_err` in that cycle and is discarded. The stored contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming flit valid |
| in_vc | input | VC_W | VC number of the incoming flit |
| in_type | input | 2 | Flit type (see R9) |
| in_data | input | DATA_W | Flit payload |
| rc_req | output | NUM_VC | Route computation request per VC |
| rc_ack | input | NUM_VC | Route computation done per VC |
| rc_port | input | PORT_W | Output port returned by route computation |
| va_req | output | NUM_VC | Output-VC request per VC |
| va_grant | input | NUM_VC | Output-VC grant per VC |
| va_ovc | input | OVC_W | Granted output VC |
| sa_req | output | NUM_VC | Switch slot bid per VC |
| sa_grant | input | NUM_VC | Switch slot grant, at most one bit set |
| out_valid | output | 1 | A flit departs this cycle |
| out_type | output | 2 | Type of the departing flit |
| out_data | output | DATA_W | Payload of the departing flit |
| out_port | output | PORT_W | Route of the departing flit's packet |
| out_ovc | output | OVC_W | Output VC of the departing flit's packet |
| cred_valid | input | 1 | Credit return valid |
| cred_vc | input | VC_W | VC receiving the returned credit |
| stall_pkt | output | NUM_VC | Packet-level stall per VC |
| stall_flit | output | NUM_VC | Flit-level stall per VC |
| overflow_err | output | 1 | Write to a full VC FIFO, flit dropped |

## Verification
Requests, bids and stalls follow the registered phase and appear one edge after the event that changed it. A flit written at edge k therefore raises `rc_req` only after edge k+1, and an acknowledge or grant shows its effect in the following cycle. Departures, the overflow flag and the stall bits depend combinationally on the inputs of the current cycle. The bench drives every input just after a falling edge, lets it settle for two nanoseconds, samples all outputs before the next rising edge, and only then advances. Credit changes have no port of their own, so they are checked through whether `sa_req` is present one cycle later.

// File: rtl/vcin_pkg.sv
package vcin_pkg;
  typedef enum logic [1:0] {
    VC_IDLE   = 2'd0,
    VC_ROUTE  = 2'd1,
    VC_WAITVC = 2'd2,
    VC_ACTIVE = 2'd3
  } vc_state_e;

  // bit 1 of the flit type marks the last flit of a packet
  function automatic logic ends_packet(input logic [1:0] ftype);
    return ftype[1];
  endfunction
endpackage

// File: rtl/vcin_fifo.sv
module vcin_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 10,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic [CNT_W-1:0] count,
  output logic             overflow
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, wr_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c,
                                                input logic up, input logic dn);
    return c + CNT_W'(up) - CNT_W'(dn);
  endfunction

  assign full     = (cnt_q == CNT_W'(DEPTH));
  assign wr_ok    = wr_req && !full;
  assign overflow = wr_req && full;
  assign rd_data  = mem[rp_q];
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= ptr_inc(wp_q);
      if (rd_en) rp_q <= ptr_inc(rp_q);
      cnt_q <= cnt_next(cnt_q, wr_ok, rd_en);
    end
  end

  // R6: a departure never reads an empty FIFO
  p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (cnt_q != '0));

  // R11: a dropped write leaves the stored count unchanged
  p_drop_keeps_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !rd_en) |=> (cnt_q == $past(cnt_q)));

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
endmodule

// File: rtl/vcin_vc_ctrl.sv
module vcin_vc_ctrl
  import vcin_pkg::*;
#(
  parameter int PORT_W  = 3,
  parameter int OVC_W   = 2,
  parameter int CREDITS = 4,
  parameter int CNT_W   = 3,
  localparam int CRED_W = $clog2(CREDITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  buf_cnt,
  input  logic [1:0]        front_type,
  input  logic              rc_ack,
  input  logic [PORT_W-1:0] rc_port,
  input  logic              va_grant,
  input  logic [OVC_W-1:0]  va_ovc,
  input  logic              sa_grant,
  input  logic              cred_ret,
  output logic              rc_req,
  output logic              va_req,
  output logic              sa_req,
  output logic              pop,
  output logic [PORT_W-1:0] route,
  output logic [OVC_W-1:0]  ovc,
  output logic              stall_pkt,
  output logic              stall_flit
);
  vc_state_e         state_q;
  logic [PORT_W-1:0] route_q;
  logic [OVC_W-1:0]  ovc_q;
  logic [CRED_W-1:0] cred_q;
  logic              tail_leaves;

  function automatic logic [CRED_W-1:0] credit_next(input logic [CRED_W-1:0] c,
                                                    input logic inc, input logic dec);
    return c + CRED_W'(inc) - CRED_W'(dec);
  endfunction

  // phase after the last flit of a packet departs
  function automatic vc_state_e after_tail(input logic [CNT_W-1:0] stored);
    return (stored > CNT_W'(1)) ? VC_ROUTE : VC_IDLE;
  endfunction

  assign rc_req      = (state_q == VC_ROUTE);
  assign va_req      = (state_q == VC_WAITVC);
  assign sa_req      = (state_q == VC_ACTIVE) && (buf_cnt != '0) && (cred_q != '0);
  assign pop         = sa_req && sa_grant;
  assign tail_leaves = pop && ends_packet(front_type);
  assign stall_pkt   = (rc_req && !rc_ack) || (va_req && !va_grant);
  assign stall_flit  = (state_q == VC_ACTIVE) && !pop;
  assign route       = route_q;
  assign ovc         = ovc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= VC_IDLE;
      route_q <= '0;
      ovc_q   <= '0;
      cred_q  <= CRED_W'(CREDITS);
    end else begin
      cred_q <= credit_next(cred_q, cred_ret, pop);
      unique case (state_q)
        VC_IDLE:   if (buf_cnt != '0) state_q <= VC_ROUTE;
        VC_ROUTE:  if (rc_ack) begin
                     route_q <= rc_port;
                     state_q <= VC_WAITVC;
                   end
        VC_WAITVC: if (va_grant) begin
                     ovc_q   <= va_ovc;
                     state_q <= VC_ACTIVE;
                   end
        VC_ACTIVE: if (tail_leaves) state_q <= after_tail(buf_cnt);
        default:   state_q <= VC_IDLE;
      endcase
    end
  end

  // R2: a buffered flit in an idle VC starts routing one edge later
  p_idle_to_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == VC_IDLE && buf_cnt != '0) |=> (state_q == VC_ROUTE));

  // R3: acknowledged route is captured
  p_route_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rc_req && rc_ack) |=> (va_req && route_q == $past(rc_port)));

  // R4: granted output VC is captured
  p_ovc_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (va_req && va_grant) |=> (state_q == VC_ACTIVE && ovc_q == $past(va_ovc)));

  // R6: a departure without a return spends one credit
  p_credit_spend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !cred_ret) |=> (cred_q == $past(cred_q) - CRED_W'(1)));

  // R7: return and departure together cancel
  p_credit_cancel_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && cred_ret) |=> $stable(cred_q));

  p_credit_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cred_q <= CRED_W'(CREDITS));

  // R8: the VC leaves the active phase after its tail departs
  p_tail_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tail_leaves |=> (state_q != VC_ACTIVE));
endmodule

// File: rtl/vc_input_unit.sv
module vc_input_unit
  import vcin_pkg::*;
#(
  parameter int NUM_VC  = 4,
  parameter int DEPTH   = 4,
  parameter int DATA_W  = 8,
  parameter int PORT_W  = 3,
  parameter int OVC_W   = 2,
  parameter int CREDITS = 4,
  localparam int VC_W   = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int FLIT_W = DATA_W + 2,
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [VC_W-1:0]   in_vc,
  input  logic [1:0]        in_type,
  input  logic [DATA_W-1:0] in_data,
  output logic [NUM_VC-1:0] rc_req,
  input  logic [NUM_VC-1:0] rc_ack,
  input  logic [PORT_W-1:0] rc_port,
  output logic [NUM_VC-1:0] va_req,
  input  logic [NUM_VC-1:0] va_grant,
  input  logic [OVC_W-1:0]  va_ovc,
  output logic [NUM_VC-1:0] sa_req,
  input  logic [NUM_VC-1:0] sa_grant,
  output logic              out_valid,
  output logic [1:0]        out_type,
  output logic [DATA_W-1:0] out_data,
  output logic [PORT_W-1:0] out_port,
  output logic [OVC_W-1:0]  out_ovc,
  input  logic              cred_valid,
  input  logic [VC_W-1:0]   cred_vc,
  output logic [NUM_VC-1:0] stall_pkt,
  output logic [NUM_VC-1:0] stall_flit,
  output logic              overflow_err
);
  logic [FLIT_W-1:0] front  [NUM_VC];
  logic [PORT_W-1:0] route  [NUM_VC];
  logic [OVC_W-1:0]  ovc    [NUM_VC];
  logic [NUM_VC-1:0] pop_vec, ovf_vec;

  for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
    logic             wr_req, cred_ret;
    logic [CNT_W-1:0] cnt;

    assign wr_req   = in_valid && (in_vc == VC_W'(v));
    assign cred_ret = cred_valid && (cred_vc == VC_W'(v));

    vcin_fifo #(.DEPTH(DEPTH), .WIDTH(FLIT_W)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_req(wr_req), .wr_data({in_type, in_data}),
      .rd_en(pop_vec[v]), .rd_data(front[v]),
      .count(cnt), .overflow(ovf_vec[v])
    );

    vcin_vc_ctrl #(.PORT_W(PORT_W), .OVC_W(OVC_W), .CREDITS(CREDITS), .CNT_W(CNT_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .buf_cnt(cnt), .front_type(front[v][FLIT_W-1 -: 2]),
      .rc_ack(rc_ack[v]), .rc_port(rc_port),
      .va_grant(va_grant[v]), .va_ovc(va_ovc),
      .sa_grant(sa_grant[v]), .cred_ret(cred_ret),
      .rc_req(rc_req[v]), .va_req(va_req[v]), .sa_req(sa_req[v]),
      .pop(pop_vec[v]), .route(route[v]), .ovc(ovc[v]),
      .stall_pkt(stall_pkt[v]), .stall_flit(stall_flit[v])
    );
  end

  // departure multiplexer: the single popping VC drives the output
  always_comb begin
    logic [FLIT_W-1:0] f;
    f        = '0;
    out_port = '0;
    out_ovc  = '0;
    for (int v = 0; v < NUM_VC; v++) begin
      if (pop_vec[v]) begin
        f        = f | front[v];
        out_port = out_port | route[v];
        out_ovc  = out_ovc | ovc[v];
      end
    end
    out_type = f[FLIT_W-1 -: 2];
    out_data = f[DATA_W-1:0];
  end

  assign out_valid    = |pop_vec;
  assign overflow_err = |ovf_vec;

  // R6: at most one VC departs per cycle
  p_single_departure_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pop_vec));

  // R11: an error is only flagged for an offered flit
  p_err_needs_flit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_err |-> in_valid);
endmodule

// File: tb/tb_vc_input_unit.sv
module tb_vc_input_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [1:0] in_vc = '0;
  logic [1:0] in_type = '0;
  logic [7:0] in_data = '0;
  logic [3:0] rc_req, va_req, sa_req, stall_pkt, stall_flit;
  logic [3:0] rc_ack = '0, va_grant = '0, sa_grant = '0;
  logic [2:0] rc_port = 3'd3;
  logic [1:0] va_ovc = 2'd2;
  logic       out_valid, overflow_err;
  logic [1:0] out_type, out_ovc;
  logic [7:0] out_data;
  logic [2:0] out_port;
  logic       cred_valid = 1'b0;
  logic [1:0] cred_vc = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vc_input_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vc(in_vc), .in_type(in_type),
    .in_data(in_data), .rc_req(rc_req), .rc_ack(rc_ack), .rc_port(rc_port),
    .va_req(va_req), .va_grant(va_grant), .va_ovc(va_ovc), .sa_req(sa_req),
    .sa_grant(sa_grant), .out_valid(out_valid), .out_type(out_type), .out_data(out_data),
    .out_port(out_port), .out_ovc(out_ovc), .cred_valid(cred_valid), .cred_vc(cred_vc),
    .stall_pkt(stall_pkt), .stall_flit(stall_flit), .overflow_err(overflow_err)
  );

  typedef struct packed {
    logic       iv;
    logic [1:0] vc;
    logic [1:0] ty;
    logic [7:0] d;
    logic [3:0] rca, vag, sag;
    logic [3:0] erc, eva, esa;
    logic       eo;
    logic [7:0] ed;
    logic [3:0] esp;
  } vec_t;

  // one packet of three flits on VC1, then a single-flit packet queued behind it
  localparam vec_t TBL [12] = '{
    '{1'b1, 2'd1, 2'b01, 8'hA1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0},
    '{1'b1, 2'd1, 2'b00, 8'hB1, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0},
    '{1'b1, 2'd1, 2'b10, 8'hC1, 4'h0, 4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 1'b0, 8'h00, 4'h2},
    '{1'b0, 2'd0, 2'b00, 8'h00, 4'h2, 4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0},
    '{1'b0, 2'd0, 2'b00, 8'h00, 4'h0, 4'h2, 4'h0, 4'h0, 4'h2, 4'h0, 1'b0, 8'h00, 4'h0},
    '{1'b0, 2'd0, 2'b00, 8'h00, 4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 4'h2, 1'b1, 8'hA1, 4'h0},
    '{1'b1, 2'd1, 2'b11, 8'hD2, 4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 4'h2, 1'b1, 8'hB1, 4'h0},
    '{1'b0, 2'd0, 2'b00, 8'h00, 4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 4'h2, 1'b1, 8'hC1, 4'h0},
    '{1'b0, 2'd0, 2'b00, 8'h00, 4'h2, 4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0},
    '{1'b0, 2'd0, 2'b00, 8'h00, 4'h0, 4'h2, 4'h0, 4'h0, 4'h2, 4'h0, 1'b0, 8'h00, 4'h0},
    '{1'b0, 2'd0, 2'b00, 8'h00, 4'h0, 4'h0, 4'h2, 4'h0, 4'h0, 4'h2, 1'b1, 8'hD2, 4'h0},
    '{1'b0, 2'd0, 2'b00, 8'h00, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0, 8'h00, 4'h0}
  };

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; rc_ack = '0; va_grant = '0; sa_grant = '0; cred_valid = 0;
  endtask

  task automatic put(input logic [1:0] vc, input logic [1:0] ty, input logic [7:0] d);
    in_valid = 1; in_vc = vc; in_type = ty; in_data = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int pops;
    logic [7:0] last;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk("R1", "rc_req", rc_req, 0);
    chk("R1", "va_req", va_req, 0);
    chk("R1", "sa_req", sa_req, 0);
    chk("R1", "out_valid", out_valid, 0);
    chk("R1", "stall", {stall_pkt, stall_flit}, 0);
    chk("R1", "overflow_err", overflow_err, 0);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // vector walk
    for (int i = 0; i < 12; i++) begin
      in_valid = TBL[i].iv; in_vc = TBL[i].vc; in_type = TBL[i].ty; in_data = TBL[i].d;
      rc_ack = TBL[i].rca; va_grant = TBL[i].vag; sa_grant = TBL[i].sag;
      #2;
      chk((i >= 8) ? "R8" : "R2", "rc_req", rc_req, TBL[i].erc);
      chk("R3", "va_req", va_req, TBL[i].eva);
      chk("R5", "sa_req", sa_req, TBL[i].esa);
      chk("R6", "out_valid", out_valid, TBL[i].eo);
      chk("R10", "stall_pkt", stall_pkt, TBL[i].esp);
      if (TBL[i].eo) begin
        chk("R6", "out_data", out_data, TBL[i].ed);
        chk("R3", "out_port", out_port, 3);
        chk("R4", "out_ovc", out_ovc, 2);
      end
      tick();
    end

    // credit handling on VC1, whose credits are now spent
    put(2'd1, 2'b01, 8'hC0); tick();
    put(2'd1, 2'b00, 8'hC1); tick();
    put(2'd1, 2'b10, 8'hC2); rc_ack = 4'h2; #2;
    chk("R9", "rc_req on tail write", rc_req[1], 1);
    tick();
    va_grant = 4'h2; tick();
    #2;
    chk("R9", "no rc/va while active", {rc_req[1], va_req[1]}, 0);
    chk("R5", "no bid at zero credit", sa_req[1], 0);
    chk("R10", "flit stall", stall_flit[1], 1);
    cred_valid = 1; cred_vc = 2'd1; tick();
    #2;
    chk("R7", "bid after return", sa_req[1], 1);
    chk("R10", "flit stall while bidding", stall_flit[1], 1);
    sa_grant = 4'h2; cred_valid = 1; cred_vc = 2'd1; #2;
    chk("R6", "data C0", out_data, 8'hC0);
    chk("R10", "no flit stall on departure", stall_flit[1], 0);
    tick();
    #2;
    chk("R7", "cancel keeps one credit", sa_req[1], 1);
    sa_grant = 4'h2; #2;
    chk("R6", "data C1", out_data, 8'hC1);
    tick();
    #2;
    chk("R6", "credit spent", sa_req[1], 0);
    cred_valid = 1; cred_vc = 2'd1; tick();
    sa_grant = 4'h2; #2;
    chk("R6", "type tail", out_type, 2'b10);
    tick();
    #2;
    chk("R8", "idle after last tail", {rc_req[1], sa_req[1], stall_flit[1]}, 0);

    // overflow on VC2
    put(2'd2, 2'b01, 8'hE0); tick();
    put(2'd2, 2'b00, 8'hE1); tick();
    put(2'd2, 2'b00, 8'hE2); tick();
    put(2'd2, 2'b10, 8'hE3); #2;
    chk("R11", "no error below full", overflow_err, 0);
    tick();
    put(2'd2, 2'b00, 8'hEE); #2;
    chk("R11", "error on full", overflow_err, 1);
    tick();
    rc_ack = 4'h4; tick();
    va_grant = 4'h4; tick();
    pops = 0; last = '0;
    for (int k = 0; k < 6; k++) begin
      #1;
      if (sa_req[2]) begin
        sa_grant = 4'h4; #1;
        pops++; last = out_data;
      end
      tick();
    end
    chk("R11", "flits drained", pops, 4);
    chk("R11", "last drained", last, 8'hE3);
    #2;
    chk("R8", "VC2 idle", {rc_req[2], sa_req[2]}, 0);

    finish_run();
  end
endmodule